// File: doc/BRIEF.md
# Quadrature Sine/Cosine Oscillator with Shift-Add Rotator

This block is a free-running numerically controlled oscillator. It produces one cosine sample (I) and one sine sample (Q) per clock. A phase register adds a frequency tuning word on every enabled clock. The top bits of that phase become a binary angle, and a folding stage maps the angle into the convergence range of a rotator. The rotator is a fully unrolled, circular, rotation-mode pipeline. Each of its stages performs one shift-and-add micro-rotation against its own arctangent constant, and no stage uses a multiplier or a sine table.

The rotator's X input starts at the reciprocal of the rotation gain, scaled to full output amplitude, and its Y input starts at zero. As a result, the X and Y values at the exit are the cosine and the sine directly, with no scaling afterwards. The folding stage handles half-circle angles. It shifts such an angle by 180 degrees and records a sign flag, which travels down the pipeline with the data; at the exit the flag negates both results. A valid bit travels alongside the samples, so a consumer only needs to watch `valid_o`.

Top module: `quadosc_top`

## Requirements
- R1: A synchronous reset clears the phase register to zero and drops `valid_o` within one clock; samples still in flight are discarded. The first enabled sample after reset uses phase 0.
- R2: The k-th enabled clock since reset (k counted from 0) produces a sample at phase equal to the sum of the tuning words of the earlier enabled clocks, modulo 2^PHASE_W. Clocks with `en` low leave the phase unchanged and produce no sample.
- R3: Each sample appears with `valid_o` high right after the 16th rising edge, counting the edge that samples `en` as the first. This is STAGES+1 registers. `valid_o` is low on every other cycle.
- R4: With A = 2^(OUT_W-1)-1 and θ = the top ANG_W bits of the phase taken as an unsigned fraction of a full turn, `cos_o` and `sin_o` lie within 4 LSB of round(A·cos 2πθ) and round(A·sin 2πθ).
- R5: All four quadrants are produced correctly. The top two angle bits 00 and 11 rotate directly; 01 and 10 are shifted by a half turn and negated at the exit. This includes exact multiples of 90 degrees and angles just below 90 degrees.
- R6: `cos_o` and `sin_o` never leave the range [-A, +A]; a result that would exceed it saturates.
- R7: A new tuning word applied on an enabled clock adds to the phase on that same clock, so the next sample already reflects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the phase and launch a sample this clock |
| ftw | input | PHASE_W | Frequency tuning word added to the phase |
| cos_o | output | OUT_W | Signed cosine (I) sample |
| sin_o | output | OUT_W | Signed sine (Q) sample |
| valid_o | output | 1 | `cos_o`/`sin_o` hold a new sample |

## Verification
The bench drives tuning words that land exactly on 0, 90, 180 and 270 degrees, and also one that steps just short of 90 degrees. A fold with the wrong quadrant test or a missing exit negation gives a result with the wrong sign, or one rotated by a quarter turn. An enable pattern with holes, and a tuning word changed on every clock, catch a phase register that advances while idle or that applies the word one clock late. Either fault shifts every later sample's phase. A reset asserted while samples are in flight, followed by a check for silence and a restart from phase 0, catches a valid chain that leaks stale samples. A long sweep checks accuracy, the exact latency and saturation at the exact ±A points.

// File: rtl/quadosc_pkg.sv
package quadosc_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // arctan(2^-idx) expressed in binary-angle units of a 2^aw full turn
  function automatic int atan_units(int idx, int aw);
    real r;
    r = $atan(2.0 ** (-idx)) / TWO_PI * (2.0 ** aw);
    return $rtoi(r + 0.5);
  endfunction

  // reciprocal of the accumulated micro-rotation gain after n stages
  function automatic real inv_gain(int n);
    real k;
    k = 1.0;
    for (int i = 0; i < n; i++) k = k / $sqrt(1.0 + 2.0 ** (-2 * i));
    return k;
  endfunction

  // initial X: full-scale amplitude with fraction bits, pre-divided by the gain
  function automatic int x_seed(int out_w, int frac, int n);
    return $rtoi(((2.0 ** (out_w - 1)) - 1.0) * (2.0 ** frac) * inv_gain(n) + 0.5);
  endfunction

  // largest residual angle expected after n stages (last constant plus rounding)
  function automatic int residual_bound(int aw, int n);
    return atan_units(n - 1, aw) + n;
  endfunction

endpackage

// File: rtl/quadosc_accum.sv
module quadosc_accum #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] ftw,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (rst)     phase <= '0;
    else if (en) phase <= phase + ftw;
  end

endmodule

// File: rtl/quadosc_fold.sv
module quadosc_fold #(
  parameter int ANG_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ANG_W-1:0]        ang_in,
  output logic signed [ANG_W-1:0] z_o,
  output logic                    neg_o,
  output logic                    vld_o
);

  logic                    half_turn;
  logic signed [ANG_W-1:0] z_next;

  // quadrant codes 01 and 10 lie beyond +/-90 degrees: flip the MSB (add a half turn)
  always_comb begin
    half_turn = ang_in[ANG_W-1] ^ ang_in[ANG_W-2];
    z_next    = half_turn ? {~ang_in[ANG_W-1], ang_in[ANG_W-2:0]} : ang_in;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= en;
  end

  always_ff @(posedge clk) begin
    z_o   <= z_next;
    neg_o <= half_turn;
  end

endmodule

// File: rtl/quadosc_stage.sv
module quadosc_stage #(
  parameter int W     = 19,
  parameter int ANG_W = 18,
  parameter int IDX   = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [W-1:0]     x_i,
  input  logic signed [W-1:0]     y_i,
  input  logic signed [ANG_W-1:0] z_i,
  input  logic                    neg_i,
  input  logic                    vld_i,
  output logic signed [W-1:0]     x_o,
  output logic signed [W-1:0]     y_o,
  output logic signed [ANG_W-1:0] z_o,
  output logic                    neg_o,
  output logic                    vld_o
);

  localparam int                    STEP_INT = quadosc_pkg::atan_units(IDX, ANG_W);
  localparam logic signed [ANG_W-1:0] STEP   = ANG_W'(STEP_INT);

  logic                    turn_ccw;
  logic signed [W-1:0]     x_sh, y_sh, x_nx, y_nx;
  logic signed [ANG_W-1:0] z_nx;

  // residual >= 0: rotate forward and subtract the constant; else the reverse
  always_comb begin
    turn_ccw = !z_i[ANG_W-1];
    x_sh     = x_i >>> IDX;
    y_sh     = y_i >>> IDX;
    x_nx     = turn_ccw ? (x_i - y_sh) : (x_i + y_sh);
    y_nx     = turn_ccw ? (y_i + x_sh) : (y_i - x_sh);
    z_nx     = turn_ccw ? (z_i - STEP) : (z_i + STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  always_ff @(posedge clk) begin
    x_o   <= x_nx;
    y_o   <= y_nx;
    z_o   <= z_nx;
    neg_o <= neg_i;
  end

endmodule

// File: rtl/quadosc_shape.sv
module quadosc_shape #(
  parameter int W     = 19,
  parameter int OUT_W = 16,
  parameter int FRAC  = 2
) (
  input  logic signed [W-1:0]     x_i,
  input  logic signed [W-1:0]     y_i,
  input  logic                    neg_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);

  localparam logic signed [W-1:0] HALF_LSB = W'(1) <<< (FRAC - 1);
  localparam logic signed [W-1:0] POS_LIM  = W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [W-1:0] NEG_LIM  = -POS_LIM;

  // undo the half-turn fold, round away the fraction bits, clamp to +/-A
  function automatic logic signed [OUT_W-1:0] finish(logic signed [W-1:0] v, logic flip);
    logic signed [W-1:0] s, r;
    s = flip ? -v : v;
    r = (s + HALF_LSB) >>> FRAC;
    if (r > POS_LIM)      r = POS_LIM;
    else if (r < NEG_LIM) r = NEG_LIM;
    return OUT_W'(r);
  endfunction

  always_comb begin
    cos_o = finish(x_i, neg_i);
    sin_o = finish(y_i, neg_i);
  end

endmodule

// File: rtl/quadosc_top.sv
module quadosc_top #(
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 18,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 2,
  parameter int STAGES  = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PHASE_W-1:0]      ftw,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    valid_o
);

  localparam int W      = OUT_W + FRAC + 1;
  localparam int SEED   = quadosc_pkg::x_seed(OUT_W, FRAC, STAGES);

  // named internal events for the checker
  logic [PHASE_W-1:0]      phase_q;
  logic signed [ANG_W-1:0] fold_z;
  logic                    fold_neg, fold_vld;
  logic signed [ANG_W-1:0] exit_z;
  logic                    exit_vld;

  logic signed [W-1:0]     xs   [STAGES+1];
  logic signed [W-1:0]     ys   [STAGES+1];
  logic signed [ANG_W-1:0] zs   [STAGES+1];
  logic                    negs [STAGES+1];
  logic                    vlds [STAGES+1];

  quadosc_accum #(.PHASE_W(PHASE_W)) u_accum (
    .clk(clk), .rst(rst), .en(en), .ftw(ftw), .phase(phase_q)
  );

  quadosc_fold #(.ANG_W(ANG_W)) u_fold (
    .clk(clk), .rst(rst), .en(en),
    .ang_in(phase_q[PHASE_W-1 -: ANG_W]),
    .z_o(fold_z), .neg_o(fold_neg), .vld_o(fold_vld)
  );

  always_comb begin
    xs[0]   = W'(SEED);
    ys[0]   = '0;
    zs[0]   = fold_z;
    negs[0] = fold_neg;
    vlds[0] = fold_vld;
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    quadosc_stage #(.W(W), .ANG_W(ANG_W), .IDX(i)) u_stage (
      .clk(clk), .rst(rst),
      .x_i(xs[i]), .y_i(ys[i]), .z_i(zs[i]), .neg_i(negs[i]), .vld_i(vlds[i]),
      .x_o(xs[i+1]), .y_o(ys[i+1]), .z_o(zs[i+1]), .neg_o(negs[i+1]), .vld_o(vlds[i+1])
    );
  end

  assign exit_z   = zs[STAGES];
  assign exit_vld = vlds[STAGES];
  assign valid_o  = exit_vld;

  quadosc_shape #(.W(W), .OUT_W(OUT_W), .FRAC(FRAC)) u_shape (
    .x_i(xs[STAGES]), .y_i(ys[STAGES]), .neg_i(negs[STAGES]),
    .cos_o(cos_o), .sin_o(sin_o)
  );

endmodule

// File: rtl/quadosc_checker.sv
module quadosc_checker #(
  parameter int PHASE_W = 32,
  parameter int ANG_W   = 18,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 15
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [PHASE_W-1:0]      ftw,
  input logic [PHASE_W-1:0]      phase_q,
  input logic signed [ANG_W-1:0] fold_z,
  input logic                    fold_vld,
  input logic signed [ANG_W-1:0] exit_z,
  input logic                    exit_vld,
  input logic signed [OUT_W-1:0] cos_o,
  input logic signed [OUT_W-1:0] sin_o,
  input logic                    valid_o
);

  localparam int LAT = STAGES + 1;
  localparam logic signed [ANG_W-1:0] QTR  = ANG_W'(64'sd1 <<< (ANG_W - 2));
  localparam logic signed [ANG_W-1:0] ZLIM = ANG_W'(quadosc_pkg::residual_bound(ANG_W, STAGES));
  localparam logic signed [OUT_W-1:0] AMP  = OUT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);

  // independent record of enables, aged by one per clock
  logic [LAT-1:0] en_hist;
  always_ff @(posedge clk) begin
    if (rst) en_hist <= '0;
    else     en_hist <= {en_hist[LAT-2:0], en};
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && phase_q == '0));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
    en |=> phase_q == $past(phase_q + ftw));

  a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase_q));

  a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
    valid_o == en_hist[LAT-1]);

  a_r5_fold_in_range: assert property (@(posedge clk) disable iff (rst)
    fold_vld |-> (fold_z >= -QTR && fold_z <= QTR));

  a_r4_residual_converged: assert property (@(posedge clk) disable iff (rst)
    exit_vld |-> (exit_z >= -ZLIM && exit_z <= ZLIM));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (cos_o <= AMP && cos_o >= -AMP && sin_o <= AMP && sin_o >= -AMP));

endmodule

bind quadosc_top quadosc_checker #(
  .PHASE_W(PHASE_W), .ANG_W(ANG_W), .OUT_W(OUT_W), .STAGES(STAGES)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .ftw(ftw), .phase_q(phase_q),
  .fold_z(fold_z), .fold_vld(fold_vld), .exit_z(exit_z), .exit_vld(exit_vld),
  .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o)
);

// File: tb/sim_quadosc_top.sv
`timescale 1ns/1ps
module sim_quadosc_top;

  localparam int  PW   = 32;
  localparam int  AW   = 18;
  localparam int  OW   = 16;
  localparam int  LAT  = 16;
  localparam int  TOL  = 4;
  localparam int  AMPL = 32767;
  localparam real TAU  = 6.283185307179586;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 en  = 1'b0;
  logic [PW-1:0]        ftw = '0;
  logic signed [OW-1:0] cos_o, sin_o;
  logic                 valid_o;

  always #5 clk = ~clk;

  quadosc_top u0 (
    .clk(clk), .rst(rst), .en(en), .ftw(ftw),
    .cos_o(cos_o), .sin_o(sin_o), .valid_o(valid_o)
  );

  typedef struct {
    int      stamp;
    int      exp_c;
    int      exp_s;
    string   tag;
  } item_t;

  item_t         sb[$];
  int            cyc = 0;
  int            n_cmp = 0;
  int            n_bad = 0;
  logic [PW-1:0] model_phase = '0;
  string         cur_tag = "R1";
  bit            done = 1'b0;

  function automatic int rnd(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check(string tag, string what, int act, int exp, bit ok);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // driver side: model the phase register and push expected samples
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      sb.delete();
      model_phase = '0;
    end else if (en) begin
      item_t it;
      real   ang;
      ang      = TAU * real'(model_phase >> (PW - AW)) / (2.0 ** AW);
      it.stamp = cyc;
      it.exp_c = rnd(AMPL * $cos(ang));
      it.exp_s = rnd(AMPL * $sin(ang));
      it.tag   = cur_tag;
      sb.push_back(it);
      model_phase = model_phase + ftw;
    end
  end

  // monitor side: compare results as they emerge (R3 timing, R4/R5 values, R6 bound)
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check("R3", "unexpected valid", 1, 0, 1'b0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check("R3", "latency", cyc - it.stamp + 1, LAT, (cyc - it.stamp + 1) == LAT);
          check(it.tag, "cos", int'(cos_o), it.exp_c,
                (int'(cos_o) - it.exp_c <= TOL) && (it.exp_c - int'(cos_o) <= TOL));
          check(it.tag, "sin", int'(sin_o), it.exp_s,
                (int'(sin_o) - it.exp_s <= TOL) && (it.exp_s - int'(sin_o) <= TOL));
          check("R6", "cos bound", int'(cos_o), AMPL, int'(cos_o) <= AMPL && int'(cos_o) >= -AMPL);
          check("R6", "sin bound", int'(sin_o), AMPL, int'(sin_o) <= AMPL && int'(sin_o) >= -AMPL);
        end
      end else if (sb.size() != 0 && (cyc - sb[0].stamp + 1) >= LAT) begin
        check("R3", "missing valid", 0, 1, 1'b0);
        void'(sb.pop_front());
      end
    end
  end

  task automatic burst(logic [PW-1:0] word, int n, string tag);
    cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en  = 1'b1;
      ftw = word;
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (sb.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet while and right after reset
    for (int i = 0; i < 3; i++) begin
      check("R1", "valid during reset", int'(valid_o), 0, valid_o == 1'b0);
      @(negedge clk);
    end
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after reset", int'(valid_o), 0, valid_o == 1'b0);

    // R5: exact quarter turns, then steps just below 90 degrees
    burst(32'h4000_0000, 8, "R5");
    drain();
    do_reset(2);
    burst(32'h3FFF_C000, 8, "R5");
    drain();

    // R2: enable with holes, phase must hold during idle clocks
    cur_tag = "R2";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      en  = (i % 3 != 1);
      ftw = 32'h0123_4567;
    end
    @(negedge clk);
    en = 1'b0;
    drain();

    // R7: a different tuning word on every enabled clock
    cur_tag = "R7";
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      en  = 1'b1;
      ftw = 32'h0100_0000 * (i + 1) + 32'h0000_3A00;
    end
    @(negedge clk);
    en = 1'b0;
    drain();

    // R4: long sweep across many turns (phase wraps several times)
    burst(32'h00A3_D70B, 600, "R4");
    drain();
    burst(32'h9E37_79B9, 200, "R4");
    drain();

    // R1: reset with samples in flight; nothing stale may emerge
    cur_tag = "R1";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      en  = 1'b1;
      ftw = 32'h1234_5678;
    end
    do_reset(2);
    for (int i = 0; i < 24; i++) begin
      check("R1", "flushed valid", int'(valid_o), 0, valid_o == 1'b0);
      @(negedge clk);
    end
    // R1: restart from phase 0
    burst(32'h2000_0000, 8, "R1");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: actual=%0d cycles expected completion before %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule